// File: doc/BRIEF.md
# Memory Patrol and Demand Scrubber

This engine sits next to a memory controller and stops soft errors from building up in memory. In the background it walks every line of the address space, one line at a time, with evenly spaced reads. When the ECC result for a line comes back correctable, it writes the corrected data back to that same line. A full sweep fits inside a programmed period. The period is either a long normal interval or an accelerated interval that is six times shorter, and a configuration bit can switch patrolling off.

The same engine also performs demand scrubbing. It watches the responses to ordinary functional reads. When one of them reports a correctable error, it queues a write-back of the corrected data to that address, so the line does not have to wait for the patrol pointer to reach it. An uncorrectable error found by a patrol read is not written back. Because no consumer has used that data yet, the engine reports it on a separate non-execution-path event output that carries the line address. Functional traffic always has priority on the shared request port.

Top module: `mem_scrubber`

## Requirements
- R1: Patrol reads visit line addresses in ascending order, one line per read, and wrap from the last line (2^ADDR_W - 1) back to line 0.
- R2: A patrol read response with the correctable flag set and the uncorrectable flag clear causes a write of the returned (corrected) data to the same line, issued with `mem_req_tag` = 1.
- R3: One tick equals `cfg_prescale` clock cycles, and a value of 0 counts as 1. One line is read every (24 × UNIT_TICKS / lines) ticks in normal mode and every (4 × UNIT_TICKS / lines) ticks when `cfg_accel` = 1. With the defaults (16 lines, UNIT_TICKS = 8, prescale 2), a sweep therefore lasts 384 cycles in normal mode and 64 cycles in accelerated mode.
- R4: Reset leaves patrol enabled, in normal mode, with prescale PRESCALE_RST, no request on the memory port and all counters at zero. While `cfg_patrol_off` = 1, no new patrol reads are issued and no sweep completes.
- R5: A functional read response (`mem_rsp_tag` = 0) with the correctable flag set and the uncorrectable flag clear results in a write of the returned data to `mem_rsp_addr`, issued with `mem_req_tag` = 0.
- R6: A patrol read response with the uncorrectable flag set produces a one-cycle `ne_valid` pulse in the next cycle, with `ne_addr` equal to that line, and no write-back. A functional uncorrectable response produces neither.
- R7: Arbitration order is functional request first, then queued demand write-back, then patrol access. A patrol read that is waiting for the port keeps its address until it is granted.
- R8: Demand write-backs are held in a 2-entry queue. A correctable functional response that arrives while the queue is full and not being drained is dropped and sets `dmd_overflow`, which stays set until reset.
- R9: `sweep_ce_cnt` and `sweep_ue_cnt` count the correctable lines fixed and the uncorrectable lines reported by patrol in the current sweep. Both clear when the read of line 0 is granted.
- R10: `sweep_done` pulses for exactly one cycle each time the patrol pointer wraps from the last line back to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the three configuration fields below |
| cfg_patrol_off | input | 1 | 1 = patrol scrubbing disabled |
| cfg_accel | input | 1 | 1 = accelerated sweep period |
| cfg_prescale | input | PS_W | Clock cycles per tick |
| fn_req_valid | input | 1 | Functional request present |
| fn_req_write | input | 1 | Functional request is a write |
| fn_req_addr | input | ADDR_W | Functional request line address |
| fn_req_wdata | input | DATA_W | Functional write data |
| fn_req_ready | output | 1 | Functional request accepted |
| mem_req_valid | output | 1 | Request to memory |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory request line address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_req_tag | output | 1 | 1 = patrol access, 0 = functional or demand |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_tag | input | 1 | Echo of the request tag |
| mem_rsp_addr | input | ADDR_W | Echo of the read address |
| mem_rsp_data | input | DATA_W | Corrected read data |
| mem_rsp_ce | input | 1 | Correctable error was corrected |
| mem_rsp_ue | input | 1 | Uncorrectable error detected |
| ne_valid | output | 1 | Non-execution-path uncorrectable event |
| ne_addr | output | ADDR_W | Line of that event |
| sweep_done | output | 1 | Patrol pointer wrapped |
| sweep_ce_cnt | output | ADDR_W+1 | Correctable lines fixed this sweep |
| sweep_ue_cnt | output | ADDR_W+1 | Uncorrectable lines reported this sweep |
| dmd_overflow | output | 1 | Sticky demand-queue overflow |

## Verification
The hardest state to reach is a full demand queue. Getting there needs write-backs blocked while correctable functional responses keep arriving. The bench creates this by issuing four back-to-back functional reads to lines marked correctable. The continuous functional traffic keeps the queue from draining until the third response arrives. The expected write sequence is therefore the first, second and fourth lines, with the third dropped and the overflow flag raised. Sweep timing is measured as the cycle distance between successive sweep-done pulses after the configuration has settled.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {PS_IDLE, PS_RD, PS_WAIT, PS_WB} pat_state_e;

  localparam int NORMAL_UNITS = 24;
  localparam int ACCEL_UNITS  = 4;

  // ticks between two patrol reads for the chosen period
  function automatic int line_interval(input logic accel, input int unit_ticks, input int lines);
    int units;
    int iv;
    units = accel ? ACCEL_UNITS : NORMAL_UNITS;
    iv = (units * unit_ticks) / lines;
    return (iv < 1) ? 1 : iv;
  endfunction

endpackage

// File: rtl/scrub_timer.sv
module scrub_timer import scrub_pkg::*; #(
  parameter int PS_W       = 8,
  parameter int IV_W       = 8,
  parameter int UNIT_TICKS = 8,
  parameter int LINES      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            accel,
  input  logic [PS_W-1:0] prescale,
  output logic            expire
);

  logic [PS_W-1:0] pc;
  logic [IV_W-1:0] ic;
  logic [PS_W-1:0] ps_lim;
  logic [IV_W-1:0] iv_lim;
  logic            tick;

  always_comb begin
    ps_lim = (prescale == '0) ? '0 : prescale - 1'b1;
    iv_lim = IV_W'(line_interval(accel, UNIT_TICKS, LINES) - 1);
  end

  assign tick   = run && (pc >= ps_lim);
  assign expire = tick && (ic >= iv_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pc <= '0;
      ic <= '0;
    end else begin
      pc <= tick ? '0 : pc + 1'b1;
      if (tick) ic <= expire ? '0 : ic + 1'b1;
    end
  end

endmodule

// File: rtl/scrub_patrol.sv
module scrub_patrol import scrub_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              expire,
  input  logic              grant,
  input  logic              rsp_valid,
  input  logic              rsp_tag,
  input  logic              rsp_ce,
  input  logic              rsp_ue,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              req,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              rd_wait,
  output logic              rsp_hit,
  output logic              ne_valid,
  output logic [ADDR_W-1:0] ne_addr,
  output logic              sweep_done,
  output logic [ADDR_W:0]   ce_cnt,
  output logic [ADDR_W:0]   ue_cnt
);

  pat_state_e        st;
  logic              due;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] wb_data;
  logic              start, fix, advance, clr;

  assign rsp_hit = rsp_valid && rsp_tag && (st == PS_WAIT);
  assign fix     = rsp_hit && rsp_ce && !rsp_ue;
  assign start   = (st == PS_IDLE) && run && (due || expire);
  assign advance = (rsp_hit && !fix) || ((st == PS_WB) && grant);
  assign clr     = (st == PS_RD) && grant && (ptr == '0);

  assign req       = (st == PS_RD) || (st == PS_WB);
  assign req_write = (st == PS_WB);
  assign req_addr  = ptr;
  assign req_data  = wb_data;
  assign rd_wait   = (st == PS_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= PS_IDLE;
      due        <= 1'b0;
      ptr        <= '0;
      wb_data    <= '0;
      ne_valid   <= 1'b0;
      ne_addr    <= '0;
      sweep_done <= 1'b0;
      ce_cnt     <= '0;
      ue_cnt     <= '0;
    end else begin
      due        <= run && !start && (due || expire);
      ne_valid   <= rsp_hit && rsp_ue;
      sweep_done <= advance && (ptr == '1);
      if (rsp_hit) ne_addr <= ptr;
      if (advance) ptr <= ptr + 1'b1;
      unique case (st)
        PS_IDLE: if (start) st <= PS_RD;
        PS_RD:   if (grant) st <= PS_WAIT;
        PS_WAIT: if (rsp_hit) begin
          st      <= fix ? PS_WB : PS_IDLE;
          wb_data <= rsp_data;
        end
        PS_WB:   if (grant) st <= PS_IDLE;
        default: st <= PS_IDLE;
      endcase
      if (clr) begin
        ce_cnt <= '0;
        ue_cnt <= '0;
      end else begin
        if (fix && ce_cnt != '1) ce_cnt <= ce_cnt + 1'b1;
        if (rsp_hit && rsp_ue && ue_cnt != '1) ue_cnt <= ue_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scrub_dmd_q.sv
module scrub_dmd_q #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              valid,
  output logic              full,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid     = (cnt != '0);
  assign full      = (cnt == CNT_W'(DEPTH));
  assign do_pop    = pop && valid;
  assign do_push   = push && (!full || do_pop);
  assign head_addr = q_addr[rp];
  assign head_data = q_data[rp];

  always_ff @(posedge clk) begin
    if (do_push) begin
      q_addr[wp] <= push_addr;
      q_data[wp] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full && !do_pop) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber import scrub_pkg::*; #(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter int UNIT_TICKS   = 8,
  parameter int PS_W         = 8,
  parameter int PRESCALE_RST = 2,
  parameter int DMD_DEPTH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_patrol_off,
  input  logic              cfg_accel,
  input  logic [PS_W-1:0]   cfg_prescale,
  input  logic              fn_req_valid,
  input  logic              fn_req_write,
  input  logic [ADDR_W-1:0] fn_req_addr,
  input  logic [DATA_W-1:0] fn_req_wdata,
  output logic              fn_req_ready,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic              mem_req_tag,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_tag,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_ce,
  input  logic              mem_rsp_ue,
  output logic              ne_valid,
  output logic [ADDR_W-1:0] ne_addr,
  output logic              sweep_done,
  output logic [ADDR_W:0]   sweep_ce_cnt,
  output logic [ADDR_W:0]   sweep_ue_cnt,
  output logic              dmd_overflow
);

  localparam int LINES = 1 << ADDR_W;
  localparam int IV_W  = $clog2(NORMAL_UNITS * UNIT_TICKS + 1);

  // configuration state
  logic            patrol_off_q, accel_q;
  logic [PS_W-1:0] prescale_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      patrol_off_q <= 1'b0;
      accel_q      <= 1'b0;
      prescale_q   <= PS_W'(PRESCALE_RST);
    end else if (cfg_we) begin
      patrol_off_q <= cfg_patrol_off;
      accel_q      <= cfg_accel;
      prescale_q   <= cfg_prescale;
    end
  end

  // named internal events
  logic              run, expire;
  logic              pat_req, pat_write, pat_rd_wait, pat_rsp_hit, pat_grant;
  logic [ADDR_W-1:0] pat_addr;
  logic [DATA_W-1:0] pat_data;
  logic              dmd_push, dmd_pop, dmd_valid, dmd_full;
  logic [ADDR_W-1:0] dmd_addr;
  logic [DATA_W-1:0] dmd_data;

  assign run      = !patrol_off_q;
  assign dmd_push = mem_rsp_valid && !mem_rsp_tag && mem_rsp_ce && !mem_rsp_ue;

  scrub_timer #(.PS_W(PS_W), .IV_W(IV_W), .UNIT_TICKS(UNIT_TICKS), .LINES(LINES)) u_timer (
    .clk, .rst_n, .run, .accel(accel_q), .prescale(prescale_q), .expire
  );

  scrub_patrol #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_patrol (
    .clk, .rst_n, .run, .expire, .grant(pat_grant),
    .rsp_valid(mem_rsp_valid), .rsp_tag(mem_rsp_tag), .rsp_ce(mem_rsp_ce),
    .rsp_ue(mem_rsp_ue), .rsp_data(mem_rsp_data),
    .req(pat_req), .req_write(pat_write), .req_addr(pat_addr), .req_data(pat_data),
    .rd_wait(pat_rd_wait), .rsp_hit(pat_rsp_hit),
    .ne_valid, .ne_addr, .sweep_done, .ce_cnt(sweep_ce_cnt), .ue_cnt(sweep_ue_cnt)
  );

  scrub_dmd_q #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DMD_DEPTH)) u_dmd (
    .clk, .rst_n, .push(dmd_push), .push_addr(mem_rsp_addr), .push_data(mem_rsp_data),
    .pop(dmd_pop), .valid(dmd_valid), .full(dmd_full), .head_addr(dmd_addr),
    .head_data(dmd_data), .overflow(dmd_overflow)
  );

  // fixed-priority port mux: functional, demand write-back, patrol
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    mem_req_tag   = 1'b0;
    dmd_pop       = 1'b0;
    pat_grant     = 1'b0;
    if (fn_req_valid) begin
      mem_req_valid = 1'b1;
      mem_req_write = fn_req_write;
      mem_req_addr  = fn_req_addr;
      mem_req_wdata = fn_req_wdata;
    end else if (dmd_valid) begin
      mem_req_valid = 1'b1;
      mem_req_write = 1'b1;
      mem_req_addr  = dmd_addr;
      mem_req_wdata = dmd_data;
      dmd_pop       = mem_req_ready;
    end else if (pat_req) begin
      mem_req_valid = 1'b1;
      mem_req_write = pat_write;
      mem_req_addr  = pat_addr;
      mem_req_wdata = pat_data;
      mem_req_tag   = 1'b1;
      pat_grant     = mem_req_ready;
    end
  end

  assign fn_req_ready = mem_req_ready;

endmodule

// File: rtl/scrub_chk.sv
module scrub_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fn_req_valid,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic              mem_req_tag,
  input logic [ADDR_W-1:0] mem_rsp_addr,
  input logic              mem_rsp_ue,
  input logic              ne_valid,
  input logic [ADDR_W-1:0] ne_addr,
  input logic              sweep_done,
  input logic              dmd_overflow,
  input logic              dmd_push,
  input logic              dmd_pop,
  input logic              dmd_full,
  input logic              pat_rd_wait,
  input logic              pat_grant,
  input logic              pat_rsp_hit,
  input logic [ADDR_W-1:0] pat_addr
);

  assert_fn_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fn_req_valid |-> mem_req_valid && !mem_req_tag);

  assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd_wait && !pat_grant |=> pat_rd_wait && $stable(pat_addr));

  assert_ue_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rsp_hit && mem_rsp_ue |=> ne_valid && ne_addr == $past(mem_rsp_addr));

  assert_ue_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rsp_hit && mem_rsp_ue |=> !(mem_req_valid && mem_req_write && mem_req_tag));

  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_push && dmd_full && !dmd_pop |=> dmd_overflow);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_overflow |=> dmd_overflow);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);

endmodule

bind mem_scrubber scrub_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mem_scrubber_tb.sv
module mem_scrubber_tb;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NL = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          cfg_we = 0, cfg_patrol_off = 0, cfg_accel = 0;
  logic [7:0]    cfg_prescale = 8'd2;
  logic          fn_req_valid = 0, fn_req_write = 0;
  logic [AW-1:0] fn_req_addr = '0;
  logic [DW-1:0] fn_req_wdata = '0;
  logic          fn_req_ready;
  logic          mem_req_valid, mem_req_write, mem_req_tag;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_req_ready = 1'b1;
  logic          rsp_valid = 0, rsp_tag = 0, rsp_ce = 0, rsp_ue = 0;
  logic [AW-1:0] rsp_addr = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          ne_valid, sweep_done, dmd_overflow;
  logic [AW-1:0] ne_addr;
  logic [AW:0]   sweep_ce_cnt, sweep_ue_cnt;

  mem_scrubber u_dut (
    .clk, .rst_n, .cfg_we, .cfg_patrol_off, .cfg_accel, .cfg_prescale,
    .fn_req_valid, .fn_req_write, .fn_req_addr, .fn_req_wdata, .fn_req_ready,
    .mem_req_valid, .mem_req_write, .mem_req_addr, .mem_req_wdata, .mem_req_tag,
    .mem_req_ready, .mem_rsp_valid(rsp_valid), .mem_rsp_tag(rsp_tag),
    .mem_rsp_addr(rsp_addr), .mem_rsp_data(rsp_data), .mem_rsp_ce(rsp_ce),
    .mem_rsp_ue(rsp_ue), .ne_valid, .ne_addr, .sweep_done, .sweep_ce_cnt,
    .sweep_ue_cnt, .dmd_overflow
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pat_reads = 0;
  int ne_seen = 0;
  int dones = 0;
  logic [AW-1:0] next_pat = '0;

  // memory model: corrected data stored, error flags per line
  logic [DW-1:0] mem [NL];
  logic          ce_f [NL];
  logic          ue_f [NL];

  // scoreboard of expected writes {tag, addr, data}
  logic [AW+DW:0] exp_q [$];

  function automatic logic [DW-1:0] dval(input int a);
    return 32'h5A00_0000 ^ (32'h0001_0307 * a);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr]  <= mem_req_wdata;
        ce_f[mem_req_addr] <= 1'b0;
      end else begin
        rsp_valid <= 1'b1;
        rsp_tag   <= mem_req_tag;
        rsp_addr  <= mem_req_addr;
        rsp_data  <= mem[mem_req_addr];
        rsp_ce    <= ce_f[mem_req_addr];
        rsp_ue    <= ue_f[mem_req_addr];
      end
    end
  end

  // monitor: pops expectations as the design issues writes
  always @(negedge clk) begin
    if (rst_n) begin
      if (sweep_done) dones++;
      if (ne_valid) begin
        ne_seen++;
        check(ne_addr == 4'd12, "R6 ne_addr", 64'(ne_addr), 64'd12);
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2/R5 unexpected write", 64'(mem_req_addr), 64'hFFFF);
          end else begin
            logic [AW+DW:0] e;
            e = exp_q.pop_front();
            check({mem_req_tag, mem_req_addr, mem_req_wdata} == e, "R2/R5/R8 write-back",
                  64'({mem_req_tag, mem_req_addr, mem_req_wdata}), 64'(e));
          end
        end else if (mem_req_tag) begin
          pat_reads++;
          check(mem_req_addr == next_pat, "R1 patrol order", 64'(mem_req_addr), 64'(next_pat));
          next_pat = mem_req_addr + 1'b1;
        end
      end
    end
  end

  task automatic cfg(input logic off, input logic acc, input logic [7:0] ps);
    @(negedge clk);
    cfg_we = 1; cfg_patrol_off = off; cfg_accel = acc; cfg_prescale = ps;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_sweep(output int t);
    do @(negedge clk); while (!sweep_done);
    t = cyc;
  endtask

  task automatic fn_read(input logic [AW-1:0] a);
    @(negedge clk);
    fn_req_valid = 1; fn_req_write = 0; fn_req_addr = a;
    @(negedge clk);
    fn_req_valid = 0;
  endtask

  task automatic run_all();
    int t0, t1, t2, pr, dn, ns;
    // reset state (R4)
    repeat (3) @(negedge clk);
    check(!mem_req_valid, "R4 reset no request", 64'(mem_req_valid), 0);
    check(sweep_ce_cnt == 0 && sweep_ue_cnt == 0, "R4 reset counters",
          64'({sweep_ce_cnt, sweep_ue_cnt}), 0);
    check(!dmd_overflow && !sweep_done && !ne_valid, "R4 reset flags",
          64'({dmd_overflow, sweep_done, ne_valid}), 0);
    rst_n = 1;

    // normal sweeps with default config (R2, R3, R6, R9, R10)
    exp_q.push_back({1'b1, 4'd3, dval(3)});
    exp_q.push_back({1'b1, 4'd9, dval(9)});
    wait_sweep(t1);
    check(sweep_ce_cnt == 2, "R9 ce count sweep1", 64'(sweep_ce_cnt), 2);
    check(sweep_ue_cnt == 1, "R9 ue count sweep1", 64'(sweep_ue_cnt), 1);
    check(exp_q.size() == 0, "R2 patrol fixes done", 64'(exp_q.size()), 0);
    check(ne_seen == 1, "R6 one ne event", 64'(ne_seen), 1);
    wait_sweep(t2);
    check(t2 - t1 == 384, "R3 normal period", 64'(t2 - t1), 384);
    check(sweep_ce_cnt == 0 && sweep_ue_cnt == 1, "R9 counts cleared per sweep",
          64'({sweep_ce_cnt, sweep_ue_cnt}), 64'(1));
    check(!ce_f[3] && !ce_f[9] && mem[3] == dval(3), "R2 memory corrected",
          64'({ce_f[3], ce_f[9]}), 0);
    @(negedge clk);
    check(!sweep_done, "R10 single-cycle pulse", 64'(sweep_done), 0);

    // accelerated period (R3)
    cfg(1'b0, 1'b1, 8'd2);
    wait_sweep(t0); wait_sweep(t1); wait_sweep(t2);
    check(t2 - t1 == 64, "R3 accel period", 64'(t2 - t1), 64);
    cfg(1'b0, 1'b1, 8'd4);
    wait_sweep(t0); wait_sweep(t1); wait_sweep(t2);
    check(t2 - t1 == 128, "R3 prescale 4", 64'(t2 - t1), 128);

    // functional priority over pending patrol (R7)
    cfg(1'b0, 1'b1, 8'd2);
    repeat (10) @(negedge clk);
    pr = pat_reads;
    for (int i = 0; i < 24; i++) begin
      fn_req_valid = 1; fn_req_write = 0; fn_req_addr = AW'(i);
      #1;
      if (i % 4 == 0)
        check(mem_req_valid && !mem_req_tag && mem_req_addr == AW'(i), "R7 functional first",
              64'({mem_req_tag, mem_req_addr}), 64'(i % NL));
      @(negedge clk);
    end
    fn_req_valid = 0;
    check(pat_reads == pr, "R7 no patrol during traffic", 64'(pat_reads - pr), 0);
    repeat (20) @(negedge clk);
    check(pat_reads > pr, "R7 patrol resumes", 64'(pat_reads - pr), 1);

    // disable (R4)
    cfg(1'b1, 1'b0, 8'd2);
    repeat (20) @(negedge clk);
    pr = pat_reads; dn = dones;
    repeat (400) @(negedge clk);
    check(pat_reads == pr, "R4 no patrol reads when off", 64'(pat_reads - pr), 0);
    check(dones == dn, "R4 no sweep when off", 64'(dones - dn), 0);

    // demand scrub (R5) and consumed UE (R6)
    ce_f[6] <= 1'b1;
    exp_q.push_back({1'b0, 4'd6, dval(6)});
    fn_read(4'd6);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0 && !ce_f[6], "R5 demand write-back", 64'(exp_q.size()), 0);
    ns = ne_seen;
    fn_read(4'd12);
    repeat (6) @(negedge clk);
    check(ne_seen == ns, "R6 consumed UE not reported", 64'(ne_seen - ns), 0);

    // demand queue overflow (R8)
    ce_f[1] <= 1'b1; ce_f[2] <= 1'b1; ce_f[4] <= 1'b1; ce_f[5] <= 1'b1;
    exp_q.push_back({1'b0, 4'd1, dval(1)});
    exp_q.push_back({1'b0, 4'd2, dval(2)});
    exp_q.push_back({1'b0, 4'd5, dval(5)});
    @(negedge clk);
    check(!dmd_overflow, "R8 no overflow yet", 64'(dmd_overflow), 0);
    fn_req_valid = 1; fn_req_write = 0; fn_req_addr = 4'd1;
    @(negedge clk); fn_req_addr = 4'd2;
    @(negedge clk); fn_req_addr = 4'd4;
    @(negedge clk); fn_req_addr = 4'd5;
    @(negedge clk); fn_req_valid = 0;
    repeat (8) @(negedge clk);
    check(dmd_overflow, "R8 overflow flag", 64'(dmd_overflow), 1);
    check(exp_q.size() == 0, "R8 queued write-backs drained", 64'(exp_q.size()), 0);
    check(ce_f[4], "R8 dropped entry not written", 64'(ce_f[4]), 1);
    repeat (10) @(negedge clk);
    check(dmd_overflow, "R8 overflow sticky", 64'(dmd_overflow), 1);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      mem[i]  <= dval(i);
      ce_f[i] <= 1'b0;
      ue_f[i] <= 1'b0;
    end
    ce_f[3]  <= 1'b1;
    ce_f[9]  <= 1'b1;
    ue_f[12] <= 1'b1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    check(exp_q.size() == 0, "R2/R5 scoreboard empty", 64'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule